// File: doc/BRIEF.md
# ADC output data formatter

This block sits between the sample registers of a two-channel analog-to-digital converter and its parallel output pins. On every rising edge of the sample-rate clock it captures one word from each channel, together with a 6-bit output-mode control value and the state of the external enable pin and its strap. It recodes the captured words into offset binary, two's complement or Gray code and may invert every bit. A packing stage clocked at twice the sample rate then places the result on the output bus. That stage works in one of three ways: single data rate, split-pin double data rate (half the pins, two slots per sample), or two-channel interleave (channel A then channel B on the full bus).

Every sample period has two slots: the first slot runs from the middle of the period, and the second from the next sample-clock edge. Any control change takes effect at a sample boundary, so one sample never mixes two settings. The bus is three-stated when the output is disabled. The enable comes either from an active-low external pin or, when the strap marks that pin as used for something else, from an active-low control bit. The analog drive-level bits of the full mode register are handled outside this block and are not inputs here.

Top module: `adc_fmt_top`

## Requirements
- R1: Out of reset, before any sample is captured, `oe_o` is 1 and `data_o` is all zeros.
- R2: With `ctrl_i[1:0]` = 00, and also with the reserved value 11, the sample word goes out unchanged (offset binary).
- R3: With `ctrl_i[1:0]` = 01, the output word is the sample with its most significant bit flipped (two's complement).
- R4: With `ctrl_i[1:0]` = 10, the output word is `s ^ (s >> 1)` of the sample `s` (Gray code).
- R5: With `ctrl_i[2]` = 1, every bit of the coded word is inverted after coding and before packing.
- R6: With `ctrl_i[3]` = 1 and `ctrl_i[5]` = 0 (split-pin DDR), the first slot carries bits [H-1:0] of the coded channel A word on `data_o[H-1:0]` and the second slot carries bits [W-1:H]. The upper W-H pins are 0 in both slots (H = W/2).
- R7: With `ctrl_i[5]` = 1 (interleave), the first slot carries the full coded channel A word and the second slot carries the full coded channel B word.
- R8: When `ctrl_i[3]` and `ctrl_i[5]` are both 1, interleave behaviour (R7) applies.
- R9: With `ctrl_i[3]` = 0 and `ctrl_i[5]` = 0, both slots carry the full coded channel A word, and channel B has no effect on `data_o`.
- R10: With `oe_pin_alt_i` = 0, the output is enabled exactly when `oe_pin_ni` is 0, and `ctrl_i[4]` has no effect on `oe_o`.
- R11: With `oe_pin_alt_i` = 1, the output is enabled exactly when `ctrl_i[4]` is 0, and `oe_pin_ni` has no effect.
- R12: While `oe_o` is 0, every bit of `data_o` is high impedance.
- R13: Inputs are captured at a rising edge of `clk_i`. The first slot shows up after the next `clk2x_i` rising edge and the second slot after the following `clk_i` rising edge, and the enable holds for both slots. A new control value in every period is applied to its own sample only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample-rate clock, rising edges aligned with every other `clk2x_i` rising edge |
| clk2x_i | input | 1 | Output clock at twice the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_a_i | input | SAMPLE_W | Channel A sample, offset binary |
| chan_b_i | input | SAMPLE_W | Channel B sample, offset binary |
| ctrl_i | input | 6 | Mode: [1:0] coding, [2] invert, [3] split DDR, [4] enable (active low), [5] interleave |
| oe_pin_alt_i | input | 1 | Strap: 1 when the enable pin has an alternate function |
| oe_pin_ni | input | 1 | External output enable, active low |
| data_o | output | SAMPLE_W | Output data bus, three-stated when disabled |
| oe_o | output | 1 | High while the bus is driven |

## Verification
Inputs for sample n are applied between clock edges before the `clk_i` edge that captures them. The first-slot result is due after the `clk2x_i` edge half a sample period later. The second-slot result is due after the next `clk_i` edge, and `oe_o` is due with the first slot and holds through the second. The bench keeps a queue of expected slot pairs built from the requirements, and it compares `data_o` (including high impedance) and `oe_o` 1 ns after each of those two edges. It therefore checks every half-period, while the next sample's inputs are already applied.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  localparam int CTRL_W   = 6;
  localparam int CODE_LO  = 0;
  localparam int CODE_HI  = 1;
  localparam int BIT_INV  = 2;
  localparam int BIT_DDR  = 3;
  localparam int BIT_OE_N = 4;
  localparam int BIT_ILV  = 5;

  typedef enum logic [1:0] {
    CODE_OFFSET = 2'b00,
    CODE_TWOS   = 2'b01,
    CODE_GRAY   = 2'b10,
    CODE_RSVD   = 2'b11
  } code_e;

  typedef enum logic [1:0] {
    PK_SDR   = 2'b00,
    PK_SPLIT = 2'b01,
    PK_ILV   = 2'b10
  } pack_e;

  // interleave wins over split when both are requested
  function automatic pack_e pick_pack(input logic ddr, input logic ilv);
    if (ilv)      return PK_ILV;
    else if (ddr) return PK_SPLIT;
    else          return PK_SDR;
  endfunction

endpackage

// File: rtl/adc_fmt_coder.sv
module adc_fmt_coder
  import adc_fmt_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] raw_i,
  input  code_e        code_i,
  input  logic         inv_i,
  output logic [W-1:0] word_o
);

  logic [W-1:0] coded;

  always_comb begin
    unique case (code_i)
      CODE_TWOS: coded = {~raw_i[W-1], raw_i[W-2:0]};
      CODE_GRAY: coded = raw_i ^ (raw_i >> 1);
      default:   coded = raw_i;  // offset binary, reserved alias
    endcase
    word_o = inv_i ? ~coded : coded;
  end

endmodule

// File: rtl/adc_fmt_sample_stage.sv
module adc_fmt_sample_stage
  import adc_fmt_pkg::*;
#(
  parameter int W    = 12,
  parameter int N_CH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CH-1:0][W-1:0]   raw_i,
  input  logic [CTRL_W-1:0]        ctrl_i,
  input  logic                     oe_pin_alt_i,
  input  logic                     oe_pin_ni,
  output logic [N_CH-1:0][W-1:0]   word_o,
  output pack_e                    mode_o,
  output logic                     drive_o,
  output logic                     tog_o
);

  logic [N_CH-1:0][W-1:0] coded;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    adc_fmt_coder #(.W(W)) u_coder (
      .raw_i  (raw_i[ch]),
      .code_i (code_e'(ctrl_i[CODE_HI:CODE_LO])),
      .inv_i  (ctrl_i[BIT_INV]),
      .word_o (coded[ch])
    );
  end

  // all settings latched together at the sample boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      mode_o  <= PK_SDR;
      drive_o <= 1'b1;
      tog_o   <= 1'b0;
    end else begin
      word_o  <= coded;
      mode_o  <= pick_pack(ctrl_i[BIT_DDR], ctrl_i[BIT_ILV]);
      drive_o <= oe_pin_alt_i ? ~ctrl_i[BIT_OE_N] : ~oe_pin_ni;
      tog_o   <= ~tog_o;
    end
  end

  assert_tog_flip_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tog_o != $past(tog_o));

endmodule

// File: rtl/adc_fmt_packer.sv
module adc_fmt_packer
  import adc_fmt_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk2x_i,
  input  logic         rst_ni,
  input  logic         tog_i,
  input  logic [W-1:0] word_a_i,
  input  logic [W-1:0] word_b_i,
  input  pack_e        mode_i,
  input  logic         drive_i,
  output logic [W-1:0] bus_o,
  output logic         oe_o
);

  localparam int H = W / 2;

  logic         seen_q;
  logic         slot_q;
  logic         load_first;
  logic [W-1:0] nxt;

  // a new sample word has landed since the last 2x edge
  assign load_first = tog_i != seen_q;

  always_comb begin
    unique case (mode_i)
      PK_SPLIT: nxt = load_first ? {{(W-H){1'b0}}, word_a_i[H-1:0]}
                                 : {{H{1'b0}}, word_a_i[W-1:H]};
      PK_ILV:   nxt = load_first ? word_a_i : word_b_i;
      default:  nxt = word_a_i;
    endcase
  end

  always_ff @(posedge clk2x_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      slot_q <= 1'b0;
      bus_o  <= '0;
      oe_o   <= 1'b1;
    end else begin
      seen_q <= tog_i;
      slot_q <= ~load_first;
      bus_o  <= nxt;
      if (load_first) oe_o <= drive_i;
    end
  end

  assert_split_upper_idle_R6: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    mode_i == PK_SPLIT |=> bus_o[W-1:H] == '0);

  assert_ilv_a_first_R7: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    (mode_i == PK_ILV && load_first) |=> bus_o == $past(word_a_i));

  assert_slot_alternates_R13: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    1'b1 |=> slot_q != $past(slot_q));

endmodule

// File: rtl/adc_fmt_top.sv
module adc_fmt_top
  import adc_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk_i,
  input  logic                clk2x_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] chan_a_i,
  input  logic [SAMPLE_W-1:0] chan_b_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  input  logic                oe_pin_alt_i,
  input  logic                oe_pin_ni,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                oe_o
);

  localparam int N_CH = 2;

  logic [N_CH-1:0][SAMPLE_W-1:0] raw;
  logic [N_CH-1:0][SAMPLE_W-1:0] word;
  pack_e                         mode;
  logic                          drive;
  logic                          tog;
  logic [SAMPLE_W-1:0]           bus;

  assign raw[0] = chan_a_i;
  assign raw[1] = chan_b_i;

  adc_fmt_sample_stage #(.W(SAMPLE_W), .N_CH(N_CH)) u_sample (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .raw_i        (raw),
    .ctrl_i       (ctrl_i),
    .oe_pin_alt_i (oe_pin_alt_i),
    .oe_pin_ni    (oe_pin_ni),
    .word_o       (word),
    .mode_o       (mode),
    .drive_o      (drive),
    .tog_o        (tog)
  );

  adc_fmt_packer #(.W(SAMPLE_W)) u_packer (
    .clk2x_i  (clk2x_i),
    .rst_ni   (rst_ni),
    .tog_i    (tog),
    .word_a_i (word[0]),
    .word_b_i (word[1]),
    .mode_i   (mode),
    .drive_i  (drive),
    .bus_o    (bus),
    .oe_o     (oe_o)
  );

  assign data_o = oe_o ? bus : {SAMPLE_W{1'bz}};

  assert_pin_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_pin_alt_i && oe_pin_ni) |=> !oe_o);

  assert_pin_on_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_pin_alt_i && !oe_pin_ni) |=> oe_o);

  assert_reg_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_pin_alt_i && ctrl_i[BIT_OE_N]) |=> !oe_o);

endmodule

// File: tb/adc_fmt_top_test.sv
`timescale 1ns/1ps
module adc_fmt_top_test;

  localparam int W = 12;
  localparam int H = W / 2;

  typedef struct {
    logic [W-1:0] d0;
    logic [W-1:0] d1;
    logic         oe;
    string        tag;
    string        oe_tag;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         clk2x_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] chan_a_i = '0;
  logic [W-1:0] chan_b_i = '0;
  logic [5:0]   ctrl_i = '0;
  logic         oe_pin_alt_i = 1'b1;
  logic         oe_pin_ni = 1'b0;
  logic [W-1:0] data_o;
  logic         oe_o;

  int   checks = 0;
  int   fails = 0;
  exp_t q[$];

  adc_fmt_top #(.SAMPLE_W(W)) uut (
    .clk_i        (clk_i),
    .clk2x_i      (clk2x_i),
    .rst_ni       (rst_ni),
    .chan_a_i     (chan_a_i),
    .chan_b_i     (chan_b_i),
    .ctrl_i       (ctrl_i),
    .oe_pin_alt_i (oe_pin_alt_i),
    .oe_pin_ni    (oe_pin_ni),
    .data_o       (data_o),
    .oe_o         (oe_o)
  );

  // 200 MHz 2x clock; sample clock rises on every other 2x rise
  initial begin
    forever begin
      #2.5 clk2x_i = ~clk2x_i;
      if (clk2x_i) clk_i = ~clk_i;
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic logic [W-1:0] ref_code(input logic [W-1:0] s, input logic [5:0] c);
    logic [W-1:0] r;
    case (c[1:0])
      2'b01:   r = s ^ (1 << (W - 1));
      2'b10:   r = s ^ (s >> 1);
      default: r = s;
    endcase
    if (c[2]) r = ~r;
    return r;
  endfunction

  task automatic check_data(input string tag, input logic [W-1:0] exp);
    checks++;
    if (data_o !== exp) begin
      fails++;
      $display("FAIL %s data_o: actual %h expected %h at %0t", tag, data_o, exp, $time);
    end
  endtask

  task automatic check_oe(input string tag, input logic exp);
    checks++;
    if (oe_o !== exp) begin
      fails++;
      $display("FAIL %s oe_o: actual %b expected %b at %0t", tag, oe_o, exp, $time);
    end
  endtask

  task automatic check_slot(input exp_t e, input bit second);
    logic [W-1:0] d;
    d = second ? e.d1 : e.d0;
    if (!e.oe) begin
      d = {W{1'bz}};
      check_data("R12", d);
    end else begin
      check_data(e.tag, d);
    end
    check_oe(e.oe_tag, e.oe);
  endtask

  // drive one sample, then check previous second slot and this first slot (R13)
  task automatic put(input logic [W-1:0] a, input logic [W-1:0] b, input logic [5:0] c,
                     input logic alt, input logic pin_n, input string tag);
    exp_t         e;
    logic [W-1:0] ca;
    logic [W-1:0] cb;
    ca = ref_code(a, c);
    cb = ref_code(b, c);
    if (c[5]) begin
      e.d0 = ca; e.d1 = cb;
    end else if (c[3]) begin
      e.d0 = ca & ((1 << H) - 1);
      e.d1 = ca >> H;
    end else begin
      e.d0 = ca; e.d1 = ca;
    end
    e.oe     = alt ? ~c[4] : ~pin_n;
    e.tag    = tag;
    e.oe_tag = alt ? "R11" : "R10";
    chan_a_i = a; chan_b_i = b; ctrl_i = c;
    oe_pin_alt_i = alt; oe_pin_ni = pin_n;
    q.push_back(e);
    @(posedge clk_i); #1;
    if (q.size() >= 2) begin
      check_slot(q[0], 1'b1);
      void'(q.pop_front());
    end
    @(negedge clk_i); #1;
    check_slot(q[0], 1'b0);
  endtask

  initial begin
    repeat (4) @(posedge clk_i);
    @(negedge clk_i); #1;
    rst_ni = 1'b1;
    // R1: reset state
    check_data("R1", '0);
    check_oe("R1", 1'b1);

    // R2 / R9: offset binary, single rate, channel B ignored
    put(12'h000, 12'h5A5, 6'b000000, 1'b1, 1'b0, "R2");
    put(12'hABC, 12'h123, 6'b000000, 1'b1, 1'b0, "R9");
    put(12'hFFF, 12'h000, 6'b000000, 1'b1, 1'b1, "R9");
    put(12'h3C7, 12'hFFF, 6'b000011, 1'b1, 1'b0, "R2");
    // R3: two's complement
    put(12'h000, 12'h000, 6'b000001, 1'b1, 1'b0, "R3");
    put(12'hFFF, 12'h000, 6'b000001, 1'b1, 1'b0, "R3");
    put(12'h800, 12'h000, 6'b000001, 1'b1, 1'b0, "R3");
    // R4: Gray
    put(12'h800, 12'h000, 6'b000010, 1'b1, 1'b0, "R4");
    put(12'hFFF, 12'h000, 6'b000010, 1'b1, 1'b0, "R4");
    put(12'h555, 12'h000, 6'b000010, 1'b1, 1'b0, "R4");
    // R5: inversion after coding
    put(12'h000, 12'h000, 6'b000100, 1'b1, 1'b0, "R5");
    put(12'h555, 12'h000, 6'b000110, 1'b1, 1'b0, "R5");
    put(12'h123, 12'h000, 6'b000101, 1'b1, 1'b0, "R5");
    // R6: split DDR
    put(12'hABC, 12'h777, 6'b001000, 1'b1, 1'b0, "R6");
    put(12'hFFF, 12'h000, 6'b001000, 1'b1, 1'b0, "R6");
    put(12'h5A5, 12'h000, 6'b001101, 1'b1, 1'b0, "R6");
    // R7 / R8: interleave, and priority over split
    put(12'h123, 12'h456, 6'b100000, 1'b1, 1'b0, "R7");
    put(12'hFFF, 12'h000, 6'b100010, 1'b1, 1'b0, "R7");
    put(12'hABC, 12'hDEF, 6'b101000, 1'b1, 1'b0, "R8");
    put(12'h0F0, 12'hF0F, 6'b101101, 1'b1, 1'b0, "R8");
    // R10: external pin owns the enable, bit 4 ignored
    put(12'h111, 12'h000, 6'b010000, 1'b0, 1'b0, "R10");
    put(12'h222, 12'h000, 6'b000000, 1'b0, 1'b1, "R10");
    put(12'h333, 12'h000, 6'b010000, 1'b0, 1'b1, "R10");
    put(12'h444, 12'h000, 6'b000000, 1'b0, 1'b0, "R10");
    // R11: strap hands enable to bit 4, pin ignored
    put(12'h555, 12'h000, 6'b010000, 1'b1, 1'b0, "R11");
    put(12'h666, 12'h000, 6'b000000, 1'b1, 1'b1, "R11");
    put(12'h777, 12'h000, 6'b011000, 1'b1, 1'b0, "R11");
    put(12'h888, 12'h000, 6'b100000, 1'b1, 1'b1, "R11");

    // R13: setting changes every sample, mixed inputs
    for (int i = 0; i < 400; i++) begin
      put(W'($urandom), W'($urandom), 6'($urandom), 1'($urandom), 1'($urandom), "R13");
    end

    @(posedge clk_i); #1;
    check_slot(q[0], 1'b1);
    void'(q.pop_front());

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule